// File: doc/BRIEF.md
# SPI Write-Only Register Port

This block is a serial slave that lets a host program a small bank of byte registers over a four-wire-style serial link that has no return data line. The host lowers the active-low select, clocks in an 8-bit header (7-bit device address plus a direction bit), then a pointer byte, then one or more data bytes. Each complete data byte is committed into the register bank. The pointer's top bit decides whether successive data bytes walk up through the bank or all land on the same register.

The device answers to three addresses, and all three live in the register bank itself: one individual address and two group addresses. A host can therefore move the port to a new address, or add it to a group, through ordinary writes. A header whose address matches none of the three, or whose direction bit asks for a read, puts the port into a silent state. It stays silent until select is released and asserted again.

The serial pins are asynchronous to `clk`. They are resynchronised, and the serial clock must stay high and low for at least three `clk` periods each. Every committed data byte is also presented as a single-cycle write strobe with its index and value. This output is an announcement only and has no ready input: the serial link cannot be stalled, so a consumer must accept the strobe in the cycle it appears.

Top module: `spi_regwrite_port`

## Requirements
- R1: MOSI is sampled on each rising edge of the serial clock seen while select is low, most significant bit first. Serial clock edges while select is high have no effect.
- R2: The first seven bits of a frame are a device address. It is compared with bits [6:0] of register 0x1B (individual), register 0x1A (group 1) and register 0x19 (group 2). A match with any of them lets the frame proceed. A mismatch makes the port ignore the rest of the frame until select goes high.
- R3: The eighth bit is the direction bit, where 0 means write. If it is 1, no register changes and no strobe is issued until select has gone high and then low again.
- R4: The ninth to sixteenth bits form the pointer byte. Bit 7 is the increment flag and bits [6:0] are the register index.
- R5: Each following complete byte is written to the register at the current index. When the increment flag is 0, every data byte of the frame targets the same index.
- R6: When the increment flag is 1, the index rises by one (modulo 128) after each data byte. A data byte aimed at an index of NREG or above changes no register but still issues a strobe.
- R7: A byte left incomplete when select goes high is discarded: it writes nothing and issues no strobe.
- R8: After reset, register 0x1B holds 0x40, register 0x1A holds 0x7E, register 0x19 holds 0x7D, and all other registers hold 0x00.
- R9: Writes to registers 0x19 to 0x1B change the addresses the port answers to, starting with the next frame.
- R10: A serial clock rising edge that reaches the port in the same `clk` cycle as the rise of select is still taken. If that edge completes a data byte, the byte is written.
- R11: Each data byte produces exactly one `wr_valid` pulse of one cycle. The pulse comes with the byte's index and value and appears in the same cycle the register bank shows the new value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| spi_cs_n | input | 1 | Serial select, active low, asynchronous |
| spi_sclk | input | 1 | Serial bit clock, asynchronous |
| spi_mosi | input | 1 | Serial data in |
| wr_valid | output | 1 | One-cycle strobe for each committed data byte (no back-pressure) |
| wr_idx | output | 7 | Register index of the strobed byte |
| wr_data | output | 8 | Value of the strobed byte |
| reg_bank | output | NREG*8 | All registers, register i at bits [8i+7:8i] |

## Verification
The two functions that can fall into one `clk` cycle are the commit of the final data bit and the end-of-frame handling triggered by select rising. The bench drives the last serial clock rise and the select rise at the same instant, so the synchroniser hands both to the control logic together. The outcome is judged at the ports: the target register must hold the completed byte, exactly one extra strobe must be counted, and a later frame must start cleanly from the address phase.

// File: rtl/swp_pkg.sv
package swp_pkg;
  localparam int BYTE_W = 8;
  localparam int ADDR_W = 7;
  localparam int IDX_W  = 7;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_ADDR = 3'd1,
    ST_PTR  = 3'd2,
    ST_DATA = 3'd3,
    ST_SKIP = 3'd4
  } rx_state_t;
endpackage

// File: rtl/swp_pin_sync.sv
// Multi-stage synchroniser for a group of asynchronous pins, with one extra
// delayed copy for edge detection.
module swp_pin_sync #(
  parameter int              NPIN    = 3,
  parameter int              NSTG    = 2,
  parameter logic [NPIN-1:0] RST_VAL = '0
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NPIN-1:0] pins_in,
  output logic [NPIN-1:0] pins_s,
  output logic [NPIN-1:0] pins_q
);
  genvar p;
  generate
    for (p = 0; p < NPIN; p++) begin : g_pin
      logic [NSTG-1:0] chain;
      logic            dly;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          chain <= {NSTG{RST_VAL[p]}};
          dly   <= RST_VAL[p];
        end else begin
          chain <= {chain[NSTG-2:0], pins_in[p]};
          dly   <= chain[NSTG-1];
        end
      end
      assign pins_s[p] = chain[NSTG-1];
      assign pins_q[p] = dly;
    end
  endgenerate
endmodule

// File: rtl/swp_byte_rx.sv
// Assembles serial bits, MSB first, into bytes.
module swp_byte_rx #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic         bit_stb,
  input  logic         bit_val,
  output logic         byte_done,
  output logic [W-1:0] byte_val
);
  localparam int CW = $clog2(W);

  logic [W-2:0] sh;
  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh  <= '0;
      cnt <= '0;
    end else if (clr) begin
      cnt <= '0;
    end else if (bit_stb) begin
      sh  <= {sh[W-3:0], bit_val};
      cnt <= (cnt == CW'(W - 1)) ? '0 : cnt + 1'b1;
    end
  end

  assign byte_done = bit_stb && (cnt == CW'(W - 1));
  assign byte_val  = {sh, bit_val};
endmodule

// File: rtl/swp_frame_ctrl.sv
// Frame sequencer: address/direction, pointer, data bytes, silent state.
module swp_frame_ctrl
  import swp_pkg::*;
#(
  parameter int NMATCH = 3
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          cs_start,
  input  logic                          cs_end,
  input  logic                          byte_done,
  input  logic [BYTE_W-1:0]             byte_val,
  input  logic [NMATCH-1:0][ADDR_W-1:0] match_addr,
  output rx_state_t                     state,
  output logic                          incr,
  output logic                          wr_stb,
  output logic [IDX_W-1:0]              wr_idx,
  output logic [BYTE_W-1:0]             wr_data
);
  rx_state_t        nxt;
  logic             incr_n;
  logic [IDX_W-1:0] idx_q, idx_n;
  logic [NMATCH-1:0] hit_vec;

  genvar m;
  generate
    for (m = 0; m < NMATCH; m++) begin : g_match
      assign hit_vec[m] = (byte_val[BYTE_W-1:1] == match_addr[m]);
    end
  endgenerate

  always_comb begin
    nxt     = state;
    incr_n  = incr;
    idx_n   = idx_q;
    wr_stb  = 1'b0;
    wr_idx  = idx_q;
    wr_data = byte_val;
    unique case (state)
      ST_IDLE: if (cs_start) nxt = ST_ADDR;
      ST_ADDR: if (byte_done) begin
        if ((|hit_vec) && !byte_val[0]) nxt = ST_PTR;
        else                            nxt = ST_SKIP;
      end
      ST_PTR: if (byte_done) begin
        incr_n = byte_val[BYTE_W-1];
        idx_n  = byte_val[IDX_W-1:0];
        nxt    = ST_DATA;
      end
      ST_DATA: if (byte_done) begin
        wr_stb = 1'b1;
        if (incr) idx_n = idx_q + 1'b1;
      end
      ST_SKIP: nxt = ST_SKIP;
      default: nxt = ST_IDLE;
    endcase
    if (cs_end) nxt = ST_IDLE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      incr  <= 1'b0;
      idx_q <= '0;
    end else begin
      state <= nxt;
      incr  <= incr_n;
      idx_q <= idx_n;
    end
  end
endmodule

// File: rtl/swp_regfile.sv
// Byte register bank with three address registers and a registered strobe.
module swp_regfile
  import swp_pkg::*;
#(
  parameter int              NREG    = 32,
  parameter int              IDX_IND = 27,
  parameter int              IDX_G1  = 26,
  parameter int              IDX_G2  = 25,
  parameter logic [ADDR_W-1:0] RST_IND = 7'h40,
  parameter logic [ADDR_W-1:0] RST_G1  = 7'h7E,
  parameter logic [ADDR_W-1:0] RST_G2  = 7'h7D
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_stb,
  input  logic [IDX_W-1:0]         wr_idx_i,
  input  logic [BYTE_W-1:0]        wr_data_i,
  output logic [NREG*BYTE_W-1:0]   reg_bank,
  output logic [2:0][ADDR_W-1:0]   match_addr,
  output logic                     wr_valid,
  output logic [IDX_W-1:0]         wr_idx,
  output logic [BYTE_W-1:0]        wr_data
);
  function automatic logic [BYTE_W-1:0] rst_of(input int i);
    if (i == IDX_IND) return {1'b0, RST_IND};
    if (i == IDX_G1)  return {1'b0, RST_G1};
    if (i == IDX_G2)  return {1'b0, RST_G2};
    return '0;
  endfunction

  genvar r;
  generate
    for (r = 0; r < NREG; r++) begin : g_reg
      localparam logic [BYTE_W-1:0] RV = rst_of(r);
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
          reg_bank[r*BYTE_W +: BYTE_W] <= RV;
        else if (wr_stb && (wr_idx_i == IDX_W'(r)))
          reg_bank[r*BYTE_W +: BYTE_W] <= wr_data_i;
      end
    end
  endgenerate

  assign match_addr[0] = reg_bank[IDX_IND*BYTE_W +: ADDR_W];
  assign match_addr[1] = reg_bank[IDX_G1*BYTE_W  +: ADDR_W];
  assign match_addr[2] = reg_bank[IDX_G2*BYTE_W  +: ADDR_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_valid <= 1'b0;
      wr_idx   <= '0;
      wr_data  <= '0;
    end else begin
      wr_valid <= wr_stb;
      if (wr_stb) begin
        wr_idx  <= wr_idx_i;
        wr_data <= wr_data_i;
      end
    end
  end
endmodule

// File: rtl/spi_regwrite_port.sv
module spi_regwrite_port
  import swp_pkg::*;
#(
  parameter int NREG    = 32,
  parameter int SYNC_ST = 2
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   spi_cs_n,
  input  logic                   spi_sclk,
  input  logic                   spi_mosi,
  output logic                   wr_valid,
  output logic [6:0]             wr_idx,
  output logic [7:0]             wr_data,
  output logic [NREG*8-1:0]      reg_bank
);
  localparam int PIN_CS = 2;
  localparam int PIN_CK = 1;
  localparam int PIN_DI = 0;

  logic [2:0] pins_s, pins_q;
  logic cs_start, cs_end, bit_stb, clr;
  logic byte_done;
  logic [BYTE_W-1:0] byte_val;
  logic [2:0][ADDR_W-1:0] match_addr;
  rx_state_t st;
  logic incr, c_wr_stb;
  logic [IDX_W-1:0] c_wr_idx;
  logic [BYTE_W-1:0] c_wr_data;

  swp_pin_sync #(.NPIN(3), .NSTG(SYNC_ST), .RST_VAL(3'b100)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .pins_in({spi_cs_n, spi_sclk, spi_mosi}),
    .pins_s(pins_s), .pins_q(pins_q)
  );

  assign cs_start = !pins_s[PIN_CS] &&  pins_q[PIN_CS];
  assign cs_end   =  pins_s[PIN_CS] && !pins_q[PIN_CS];
  assign bit_stb  = pins_s[PIN_CK] && !pins_q[PIN_CK] && !pins_q[PIN_CS];
  assign clr      = cs_start || cs_end;

  swp_byte_rx #(.W(BYTE_W)) u_rx (
    .clk(clk), .rst_n(rst_n), .clr(clr),
    .bit_stb(bit_stb), .bit_val(pins_s[PIN_DI]),
    .byte_done(byte_done), .byte_val(byte_val)
  );

  swp_frame_ctrl #(.NMATCH(3)) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .cs_start(cs_start), .cs_end(cs_end),
    .byte_done(byte_done), .byte_val(byte_val),
    .match_addr(match_addr),
    .state(st), .incr(incr),
    .wr_stb(c_wr_stb), .wr_idx(c_wr_idx), .wr_data(c_wr_data)
  );

  swp_regfile #(.NREG(NREG)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .wr_stb(c_wr_stb), .wr_idx_i(c_wr_idx), .wr_data_i(c_wr_data),
    .reg_bank(reg_bank), .match_addr(match_addr),
    .wr_valid(wr_valid), .wr_idx(wr_idx), .wr_data(wr_data)
  );
endmodule

// File: rtl/swp_checker.sv
module swp_checker
  import swp_pkg::*;
#(
  parameter int NREG = 32
) (
  input logic                 clk,
  input logic                 rst_n,
  input rx_state_t            state,
  input logic                 cs_start,
  input logic                 cs_end,
  input logic                 incr,
  input logic                 wr_valid,
  input logic [IDX_W-1:0]     wr_idx,
  input logic [BYTE_W-1:0]    wr_data,
  input logic [NREG*8-1:0]    reg_bank
);
  logic [IDX_W-1:0] last_idx;
  logic             have_prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      last_idx  <= '0;
      have_prev <= 1'b0;
    end else if (cs_start) begin
      have_prev <= 1'b0;
    end else if (wr_valid) begin
      last_idx  <= wr_idx;
      have_prev <= 1'b1;
    end
  end

  // R7: frame end always returns the sequencer to idle
  p_end_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cs_end |=> (state == ST_IDLE));

  // R3: silent state never produces a strobe
  p_skip_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_SKIP) |=> !wr_valid);

  // R11: strobe coincides with the bank showing the value
  p_commit_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && (int'(wr_idx) < NREG)) |-> (reg_bank[wr_idx*8 +: 8] == wr_data));

  // R6: auto-increment walks the index by one
  p_incr_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && have_prev && incr) |-> (wr_idx == IDX_W'(last_idx + 1'b1)));

  // R5: without increment the index holds
  p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && have_prev && !incr) |-> (wr_idx == last_idx));
endmodule

bind spi_regwrite_port swp_checker #(.NREG(NREG)) u_chk (
  .clk(clk), .rst_n(rst_n), .state(st),
  .cs_start(cs_start), .cs_end(cs_end), .incr(incr),
  .wr_valid(wr_valid), .wr_idx(wr_idx), .wr_data(wr_data),
  .reg_bank(reg_bank)
);

// File: tb/tb_spi_regwrite_port.sv
`timescale 1ns/1ps
module tb_spi_regwrite_port;
  localparam int NREG = 32;
  localparam int H    = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n = 1'b1, sclk = 1'b0, mosi = 1'b0;
  logic wr_valid;
  logic [6:0] wr_idx;
  logic [7:0] wr_data;
  logic [NREG*8-1:0] reg_bank;

  int n_chk = 0, n_err = 0, n_wr = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  spi_regwrite_port #(.NREG(NREG)) dut (
    .clk(clk), .rst_n(rst_n), .spi_cs_n(cs_n), .spi_sclk(sclk),
    .spi_mosi(mosi), .wr_valid(wr_valid), .wr_idx(wr_idx),
    .wr_data(wr_data), .reg_bank(reg_bank)
  );

  always @(posedge clk) if (rst_n && wr_valid) n_wr++;

  function automatic logic [7:0] rg(input int i);
    return reg_bank[i*8 +: 8];
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_bit(input logic b);
    mosi = b; wait_n(H);
    sclk = 1'b1; wait_n(H);
    sclk = 1'b0;
  endtask

  task automatic send_byte(input logic [7:0] b);
    for (int i = 7; i >= 0; i--) send_bit(b[i]);
  endtask

  task automatic sel;   cs_n = 1'b0; wait_n(H); endtask
  task automatic desel; wait_n(H); cs_n = 1'b1; wait_n(12); endtask

  task automatic wr1(input logic [6:0] a, input logic [7:0] ptr, input logic [7:0] d);
    sel; send_byte({a, 1'b0}); send_byte(ptr); send_byte(d); desel;
  endtask

  task automatic t_reset;
    chk("R8 ind", rg(27), 8'h40);
    chk("R8 g1", rg(26), 8'h7E);
    chk("R8 g2", rg(25), 8'h7D);
    chk("R8 other", rg(3), 0);
    chk("R11 idle strobe", wr_valid, 0);
  endtask

  task automatic t_single;
    int w0 = n_wr;
    wr1(7'h40, 8'h03, 8'hA5);
    chk("R5 single write", rg(3), 8'hA5);
    chk("R11 one strobe", n_wr - w0, 1);
  endtask

  task automatic t_groups;
    wr1(7'h7E, 8'h04, 8'h11);
    chk("R2 group1", rg(4), 8'h11);
    wr1(7'h7D, 8'h05, 8'h22);
    chk("R2 group2", rg(5), 8'h22);
  endtask

  task automatic t_mismatch;
    int w0 = n_wr;
    wr1(7'h12, 8'h06, 8'h33);
    chk("R2 mismatch reg", rg(6), 0);
    chk("R2 mismatch strobe", n_wr - w0, 0);
  endtask

  task automatic t_read_bit;
    int w0 = n_wr;
    sel; send_byte({7'h40, 1'b1}); send_byte(8'h07); send_byte(8'h44); desel;
    chk("R3 read ignored", rg(7), 0);
    chk("R3 no strobe", n_wr - w0, 0);
    wr1(7'h40, 8'h07, 8'h55);
    chk("R3 next frame", rg(7), 8'h55);
  endtask

  task automatic t_incr;
    sel; send_byte(8'h80); send_byte(8'h88);
    send_byte(8'h01); send_byte(8'h02); send_byte(8'h03); desel;
    chk("R6 incr 8", rg(8), 1);
    chk("R6 incr 9", rg(9), 2);
    chk("R6 incr 10", rg(10), 3);
  endtask

  task automatic t_noincr;
    int w0 = n_wr;
    sel; send_byte(8'h80); send_byte(8'h0C);
    send_byte(8'h09); send_byte(8'h08); send_byte(8'h07); desel;
    chk("R5 same reg", rg(12), 7);
    chk("R5 neighbour", rg(13), 0);
    chk("R4 three strobes", n_wr - w0, 3);
  endtask

  task automatic t_partial;
    int w0 = n_wr;
    sel; send_byte(8'h80); send_byte(8'h8E); send_byte(8'h66);
    for (int i = 0; i < 5; i++) send_bit(1'b1);
    desel;
    chk("R7 full byte kept", rg(14), 8'h66);
    chk("R7 partial dropped", rg(15), 0);
    chk("R7 strobes", n_wr - w0, 1);
  endtask

  task automatic t_idle_clocks;
    int w0 = n_wr;
    for (int i = 0; i < 10; i++) send_bit(1'b1);
    wait_n(8);
    chk("R1 clocks while deselected", n_wr - w0, 0);
    wr1(7'h40, 8'h10, 8'h5A);
    chk("R1 msb first after idle clocks", rg(16), 8'h5A);
  endtask

  task automatic t_range;
    int w0 = n_wr;
    sel; send_byte(8'h80); send_byte(8'h9F); send_byte(8'hC1); send_byte(8'hC2); desel;
    chk("R6 last reg", rg(31), 8'hC1);
    chk("R6 beyond bank no wrap", rg(0), 0);
    chk("R6 strobes beyond bank", n_wr - w0, 2);
  endtask

  task automatic t_reprogram;
    wr1(7'h40, 8'h1B, 8'h15);
    chk("R9 new address stored", rg(27), 8'h15);
    wr1(7'h40, 8'h11, 8'h77);
    chk("R9 old address dead", rg(17), 0);
    wr1(7'h15, 8'h11, 8'h77);
    chk("R9 new address live", rg(17), 8'h77);
  endtask

  task automatic t_same_cycle;
    int w0 = n_wr;
    logic [7:0] d = 8'h3D;
    sel; send_byte({7'h15, 1'b0}); send_byte(8'h12);
    for (int i = 7; i >= 1; i--) send_bit(d[i]);
    mosi = d[0]; wait_n(H);
    sclk = 1'b1; cs_n = 1'b1; wait_n(H);
    sclk = 1'b0; wait_n(12);
    chk("R10 last bit with select rise", rg(18), 8'h3D);
    chk("R10 strobe count", n_wr - w0, 1);
    wr1(7'h15, 8'h13, 8'h4E);
    chk("R10 next frame clean", rg(19), 8'h4E);
  endtask

  initial begin
    wait_n(5);
    rst_n = 1'b1;
    wait_n(5);
    t_reset;
    t_single;
    t_groups;
    t_mismatch;
    t_read_bit;
    t_incr;
    t_noincr;
    t_partial;
    t_idle_clocks;
    t_range;
    t_reprogram;
    t_same_cycle;
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_err++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule